// File: doc/BRIEF.md
# Test Clock Divider and Output Select

This block decides what each of eight clock output groups carries on a clock-generator die. A two-bit select field picks one of three behaviours. In pass mode the synthesised clocks are forwarded unchanged. In test mode every group instead carries a fixed division of one external test clock. In off mode every group's output enable is pulled low. The block sits between the synthesis section and the pad drivers. It samples all of its clock inputs with a fast system clock `clk`, so every output is a registered, glitch-free waveform.

The control is a three-state machine. **PASS** drives the sampled synthesised clocks. **TEST** drives the divided test clocks. **HIZ** drives every clock low with its enable low. The select field goes through a synchroniser; the synchronised code is called the *target*. One transition rule, **SWITCH**, covers every pair of states: the machine moves from its state to the target only in a cycle where all clocks of the current source and all clocks of the target source are low. When no change is requested the machine **HOLD**s. A single shared down-counter, clocked by rising test-clock edges, produces both the divide-by-2 and the divide-by-4 waveforms, so their rising edges coincide with each other and with the undivided test clock.

Top module: `test_clk_mux`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every group clock is low and every group enable is high, and the block is in PASS.
- R2: Select codes 00 and 10 both mean PASS. Group g's output equals `norm_clk_i[g]` delayed by two `clk` cycles. Group bit order: 0 CPU, 1 SDRAM, 2 PCI, 3 free-running PCI, 4 reference, 5 IOAPIC, 6 IOCLK, 7 USBCLK.
- R3: With select code 01 (TEST), the reference and IOAPIC groups carry the test clock undivided.
- R4: In TEST, the CPU, SDRAM and USBCLK groups carry the test clock divided by 2.
- R5: In TEST, the PCI, free-running PCI and IOCLK groups carry the test clock divided by 4.
- R6: In TEST, every rising edge of a divide-by-4 group coincides with a rising edge of the divide-by-2 and undivided groups.
- R7: Select code 11 (HIZ) drives all eight enables low and all eight clocks low. In any other state all enables are high.
- R8: A state change happens only when the current and target sources are all low. The cycle after a change shows every clock low, and no output high pulse is shorter than the narrowest input high phase.
- R9: The select field passes through `SYNC_STAGES` register stages. Enables keep their old value for `SYNC_STAGES`+1 sampled cycles after the field changes, and change in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tclk_in | input | 1 | External test clock, sampled by `clk` |
| mode_i | input | 2 | Output select field (00/10 pass, 01 test, 11 off) |
| norm_clk_i | input | 8 | Synthesised clocks, one per group |
| grp_clk_o | output | 8 | Group clocks toward the pad drivers |
| grp_oe_o | output | 8 | Group output enables, high = driving |

## Verification
The hardest situation to reach is a select change that must wait. The current or target source has to be high at the moment the synchronised code arrives, and then the machine has to hold off until both sources drop together. The stimulus requests PASS while the synthesised clocks keep running at rates unrelated to the test clock, so the request can stall. It then freezes those clocks at a low boundary so the switch can complete. A behavioural model predicts the exact switch cycle, and a pulse-width monitor looks for runts around each switch.

// File: rtl/tmx_pkg.sv
package tmx_pkg;

    localparam int GRP_N = 8;

    localparam int G_CPU   = 0;
    localparam int G_SDRAM = 1;
    localparam int G_PCI   = 2;
    localparam int G_PCIF  = 3;
    localparam int G_REF   = 4;
    localparam int G_APIC  = 5;
    localparam int G_IO    = 6;
    localparam int G_USB   = 7;

    // largest test-mode divide exponent over all groups (divide by 4)
    localparam int DIV_LOG2_MAX = 2;

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_TEST = 2'd1,
        ST_HIZ  = 2'd2
    } run_state_e;

    // divide exponent per group in test mode: 0 = undivided, 1 = /2, 2 = /4
    function automatic int grp_div_log2(input int g);
        int r;
        case (g)
            G_REF, G_APIC:         r = 0;
            G_CPU, G_SDRAM, G_USB: r = 1;
            default:               r = 2;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tmx_mode_sync.sv
module tmx_mode_sync #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    output logic [1:0] mode_o
);

    logic [1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= 2'b00;
        end else begin
            chain[0] <= mode_i;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign mode_o = chain[STAGES-1];

endmodule

// File: rtl/tmx_div_gen.sv
module tmx_div_gen
    import tmx_pkg::*;
#(
    parameter int CNT_W = DIV_LOG2_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tclk_i,
    output logic [GRP_N-1:0] tv_o
);

    logic             t_s;
    logic             t_prev;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   taps;

    // one down-counter feeds all ratios: every counter bit rises on the
    // same test-clock edge (wrap from zero), which keeps the taps aligned
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_s    <= 1'b0;
            t_prev <= 1'b0;
            cnt    <= '0;
        end else begin
            t_s    <= tclk_i;
            t_prev <= t_s;
            if (t_s && !t_prev) cnt <= cnt - 1'b1;
        end
    end

    assign taps = {cnt, t_prev};

    generate
        for (genvar g = 0; g < GRP_N; g++) begin : g_tap
            localparam int SH = grp_div_log2(g);
            assign tv_o[g] = taps[SH];
        end
    endgenerate

    // R6
    tap_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt[CNT_W-1]) |-> ($rose(cnt[0]) && $rose(t_prev)));

endmodule

// File: rtl/tmx_sel_fsm.sv
module tmx_sel_fsm
    import tmx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_s,
    input  logic [GRP_N-1:0] norm_s,
    input  logic [GRP_N-1:0] tv,
    output logic [GRP_N-1:0] clk_o,
    output logic [GRP_N-1:0] oe_o
);

    run_state_e       state, state_nx, tgt;
    logic [GRP_N-1:0] cur_src, tgt_src;
    logic             quiet;

    function automatic logic [GRP_N-1:0] src_of(input run_state_e st,
                                                input logic [GRP_N-1:0] nv,
                                                input logic [GRP_N-1:0] t);
        logic [GRP_N-1:0] r;
        unique case (st)
            ST_PASS: r = nv;
            ST_TEST: r = t;
            default: r = '0;
        endcase
        return r;
    endfunction

    always_comb begin
        tgt = ST_PASS;
        unique case (mode_s)
            2'b00, 2'b10: tgt = ST_PASS;
            2'b01:        tgt = ST_TEST;
            2'b11:        tgt = ST_HIZ;
        endcase
    end

    assign cur_src = src_of(state, norm_s, tv);
    assign tgt_src = src_of(tgt, norm_s, tv);
    assign quiet   = ~|cur_src && ~|tgt_src;

    // SWITCH when both sides are low, otherwise HOLD
    always_comb begin
        state_nx = state;
        if (tgt != state && quiet) state_nx = tgt;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PASS;
        else        state <= state_nx;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_o <= '0;
            oe_o  <= '1;
        end else begin
            clk_o <= cur_src;
            oe_o  <= {GRP_N{state != ST_HIZ}};
        end
    end

    // R8
    switch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != $past(state)) |-> (clk_o == '0));

    // R7
    hiz_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIZ) |=> ((oe_o == '0) && (clk_o == '0)));

    // R7
    live_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_HIZ) |=> (oe_o == '1));

endmodule

// File: rtl/test_clk_mux.sv
module test_clk_mux
    import tmx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tclk_in,
    input  logic [1:0]       mode_i,
    input  logic [GRP_N-1:0] norm_clk_i,
    output logic [GRP_N-1:0] grp_clk_o,
    output logic [GRP_N-1:0] grp_oe_o
);

    localparam int CNT_W = DIV_LOG2_MAX;

    logic [1:0]       mode_s;
    logic [GRP_N-1:0] norm_s;
    logic [GRP_N-1:0] tv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) norm_s <= '0;
        else        norm_s <= norm_clk_i;
    end

    tmx_mode_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .mode_o (mode_s)
    );

    tmx_div_gen #(.CNT_W(CNT_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tclk_i (tclk_in),
        .tv_o   (tv)
    );

    tmx_sel_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_s (mode_s),
        .norm_s (norm_s),
        .tv     (tv),
        .clk_o  (grp_clk_o),
        .oe_o   (grp_oe_o)
    );

endmodule

// File: tb/tb_test_clk_mux.sv
module tb_test_clk_mux;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 2;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tclk_in = 1'b0;
    logic [1:0]   mode_i = 2'b00;
    logic [N-1:0] norm_clk_i;
    logic [N-1:0] grp_clk_o;
    logic [N-1:0] grp_oe_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    test_clk_mux #(.SYNC_STAGES(SYNC)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tclk_in    (tclk_in),
        .mode_i     (mode_i),
        .norm_clk_i (norm_clk_i),
        .grp_clk_o  (grp_clk_o),
        .grp_oe_o   (grp_oe_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic check_near(input string req, input int got, input int exp);
        checks++;
        if (got < exp - 1 || got > exp + 1) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d (+-1)", req, got, exp);
        end
    endtask

    // ---------------- stimulus generators ----------------
    int   t_half = 3, t_half_req = 3, tcnt = 0;
    int   ncnt = 0;
    bit   hold_req = 0, hold_eff = 0;

    always @(negedge clk) begin
        tcnt++;
        if (tcnt >= t_half) begin
            tcnt = 0;
            tclk_in = ~tclk_in;
            t_half = t_half_req;
        end
        ncnt++;
        if ((ncnt % 32) == 0) hold_eff = hold_req;
    end

    always_comb begin
        for (int g = 0; g < N; g++)
            norm_clk_i[g] = hold_eff ? 1'b0 : ncnt[2 + (g % 3)];
    end

    // ---------------- reference model ----------------
    logic         m_ts, m_tp;
    int           m_k;
    logic [N-1:0] m_ns;
    logic [1:0]   m_sync [SYNC];
    int           m_st;          // 0 pass, 1 test, 2 off
    logic [N-1:0] exp_clk, exp_oe;

    function automatic logic [N-1:0] m_src(input int st);
        logic [N-1:0] v;
        v = '0;
        if (st == 0) v = m_ns;
        else if (st == 1) begin
            for (int g = 0; g < N; g++) begin
                if (g == 4 || g == 5)                v[g] = m_tp;
                else if (g == 0 || g == 1 || g == 7) v[g] = (m_k % 2 == 1);
                else                                 v[g] = (m_k % 4 == 1) || (m_k % 4 == 2);
            end
        end
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ts = 0; m_tp = 0; m_k = 0; m_ns = '0; m_st = 0;
            for (int i = 0; i < SYNC; i++) m_sync[i] = 2'b00;
            exp_clk = '0; exp_oe = '1;
        end else begin
            int tg;
            logic [N-1:0] cur, nt;
            cur = m_src(m_st);
            tg  = (m_sync[SYNC-1] == 2'b11) ? 2 : (m_sync[SYNC-1] == 2'b01) ? 1 : 0;
            nt  = m_src(tg);
            exp_clk = cur;
            exp_oe  = (m_st == 2) ? '0 : '1;
            if (tg != m_st && cur == '0 && nt == '0) m_st = tg;
            if (m_ts && !m_tp) m_k++;
            m_tp = m_ts;
            m_ts = tclk_in;
            m_ns = norm_clk_i;
            for (int i = SYNC-1; i > 0; i--) m_sync[i] = m_sync[i-1];
            m_sync[0] = mode_i;
        end
    end

    // ---------------- per-cycle compare and monitors ----------------
    string        cur_req = "R1";
    bit           cnt_en = 0;
    int           rc [N];
    int           misalign = 0, align_ev = 0, runts = 0;
    int           hlen [N];
    logic [N-1:0] prev_clk = '0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [N-1:0] rose;
            check({cur_req, " clk"}, {24'd0, grp_clk_o}, {24'd0, exp_clk});
            check({cur_req, " oe"},  {24'd0, grp_oe_o},  {24'd0, exp_oe});
            rose = grp_clk_o & ~prev_clk;
            if (cnt_en) begin
                for (int g = 0; g < N; g++) if (rose[g]) rc[g]++;
                if (rose[2]) begin
                    align_ev++;
                    if (!(rose[0] && rose[4] && rose[3] && rose[1])) misalign++;
                end
            end
            for (int g = 0; g < N; g++) begin
                if (grp_clk_o[g]) hlen[g]++;
                else begin
                    if (hlen[g] > 0 && hlen[g] < 3) runts++;
                    hlen[g] = 0;
                end
            end
            prev_clk = grp_clk_o;
        end
    end

    task automatic measure(input int win, input int per);
        for (int g = 0; g < N; g++) rc[g] = 0;
        cnt_en = 1;
        repeat (win) @(negedge clk);
        cnt_en = 0;
        check_near("R3 ref",   rc[4], win / per);
        check_near("R3 apic",  rc[5], win / per);
        check_near("R4 cpu",   rc[0], win / (2*per));
        check_near("R4 sdram", rc[1], win / (2*per));
        check_near("R4 usb",   rc[7], win / (2*per));
        check_near("R5 pci",   rc[2], win / (4*per));
        check_near("R5 pcif",  rc[3], win / (4*per));
        check_near("R5 io",    rc[6], win / (4*per));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 rst clk", {24'd0, grp_clk_o}, 32'd0);
        check("R1 rst oe",  {24'd0, grp_oe_o},  32'hff);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post clk", {24'd0, grp_clk_o}, 32'd0);

        // R2: both pass codes
        cur_req = "R2";
        mode_i = 2'b00;
        repeat (120) @(negedge clk);
        mode_i = 2'b10;
        repeat (120) @(negedge clk);

        // R9 latency then R7 off state
        hold_req = 1;
        repeat (70) @(negedge clk);
        cur_req = "R9";
        mode_i = 2'b11;
        for (int i = 1; i <= SYNC + 1; i++) begin
            @(negedge clk);
            check("R9 oe held", {24'd0, grp_oe_o}, 32'hff);
        end
        @(negedge clk);
        check("R7 oe off", {24'd0, grp_oe_o}, 32'd0);
        cur_req = "R7";
        repeat (50) @(negedge clk);
        check("R7 clk low", {24'd0, grp_clk_o}, 32'd0);
        check("R7 oe low",  {24'd0, grp_oe_o},  32'd0);

        // R3/R4/R5 test mode, test clock period 6
        cur_req = "R4";
        hold_req = 0;
        mode_i = 2'b01;
        repeat (60) @(negedge clk);
        measure(240, 6);

        // R8: back to pass with running clocks, then freeze to let it switch
        cur_req = "R8";
        mode_i = 2'b00;
        repeat (150) @(negedge clk);
        hold_req = 1;
        repeat (80) @(negedge clk);
        check("R8 pass oe", {24'd0, grp_oe_o}, 32'hff);

        // second test window, test clock period 10
        cur_req = "R5";
        t_half_req = 5;
        mode_i = 2'b01;
        repeat (80) @(negedge clk);
        measure(400, 10);

        // return to pass
        cur_req = "R2";
        mode_i = 2'b10;
        repeat (100) @(negedge clk);
        hold_req = 0;
        repeat (80) @(negedge clk);

        // R6 and R8 aggregate monitors
        check("R6 align events seen", {31'd0, align_ev > 0}, 32'd1);
        check("R6 misaligned", misalign, 32'd0);
        check("R8 runt pulses", runts, 32'd0);
        finish_run();
    end

endmodule